// File: doc/BRIEF.md
# Shared-Bus Ownership Arbiter

This block decides which of several initiators on a shared pipelined system bus owns the address phase next. Each initiator raises its own request line. The arbiter returns a one-hot grant vector and an encoded owner index. The owner index names the initiator whose transfer sits in the data phase, so it trails the grant by one accepted transfer. Ownership moves only on a clock edge where the bus reports that the current transfer has completed (`xfer_ready` high). Between such edges both outputs hold steady.

One input selects the arbitration policy. In fixed-priority mode the requesting initiator with the highest index wins. In round-robin mode the search begins just after the most recently granted initiator and wraps around. When no eligible initiator is requesting, the bus goes to a default initiator chosen at build time; index 0 is the usual choice.

Split-transaction masking is a build-time option. When it is enabled, a split response seen for the current owner takes that initiator out of arbitration. The initiator returns to arbitration when its release bit is asserted. When the option is disabled, the masking logic is not built and the split inputs have no effect.

Top module: `busarb_top`

## Requirements
- R1: While reset is asserted and after it is released, `bus_grant` is the one-hot code of `DEF_MST` (bit `DEF_MST` set) and `owner_idx` equals `DEF_MST`.
- R2: On a rising edge with `xfer_ready` = 0, `bus_grant` and `owner_idx` keep their values.
- R3: `bus_grant` always has exactly one bit set. On each rising edge with `xfer_ready` = 1, `owner_idx` takes the index of the bit that was set in `bus_grant` before that edge.
- R4: With `rr_mode` = 0 (fixed priority), a ready edge grants the eligible requester with the highest index.
- R5: With `rr_mode` = 1 (round robin), a ready edge grants the first eligible requester found when searching from (last granted index + 1) upward, modulo `NUM_MST`. The last granted master is itself a candidate, and is the last one checked.
- R6: A ready edge with no bit of `bus_req` set grants `DEF_MST`.
- R7: With `SPLIT_EN` = 1, `split_resp` = 1 sets a mask bit for the initiator at `owner_idx`, and the mask takes effect in the same cycle. A masked initiator is never granted. Asserting bit i of `split_release` clears mask bit i, and the initiator becomes eligible in that same cycle.
- R8: If every requesting initiator is masked, a ready edge grants `DEF_MST`.
- R9: With `SPLIT_EN` = 0, `split_resp` and `split_release` have no effect on `bus_grant` or `owner_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rr_mode | input | 1 | 1 = round robin, 0 = fixed priority with the highest index winning |
| bus_req | input | NUM_MST | Request line of each initiator |
| xfer_ready | input | 1 | Current transfer completes on this edge; ownership may change |
| split_resp | input | 1 | A split response is being given to the initiator at `owner_idx` |
| split_release | input | NUM_MST | Bit i returns split-masked initiator i to arbitration |
| bus_grant | output | NUM_MST | One-hot address-phase grant |
| owner_idx | output | IDX_W | Index of the data-phase owner |

## Verification
A grant decision appears in `bus_grant` right after the first rising edge on which `xfer_ready` is high. `owner_idx` takes that grant's index one ready edge later. The bench changes inputs one time unit after an edge and samples both outputs one time unit after the following edge. Each expected owner is therefore the grant expected one step earlier. Mask changes from split responses and releases act within the same cycle, so their effect is checked right after the edge on which they were driven.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    typedef enum logic {
        MODE_FIXED = 1'b0,
        MODE_ROUND = 1'b1
    } arb_mode_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/busarb_mask.sv
module busarb_mask #(
    parameter int NUM_MST  = 4,
    parameter bit SPLIT_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] set_vec,
    input  logic [NUM_MST-1:0] clr_vec,
    output logic [NUM_MST-1:0] mask_now
);

    generate
        if (SPLIT_EN) begin : g_split
            logic [NUM_MST-1:0] mask_q;

            // Release has the final say, so a master set and released at once stays eligible.
            assign mask_now = (mask_q | set_vec) & ~clr_vec;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mask_q <= '0;
                else        mask_q <= mask_now;
            end
        end else begin : g_nosplit
            logic unused_split_in;
            assign unused_split_in = ^{set_vec, clr_vec, clk, rst_n};
            assign mask_now = '0;
        end
    endgenerate

endmodule

// File: rtl/busarb_pick.sv
module busarb_pick
    import busarb_pkg::*;
#(
    parameter int NUM_MST = 4,
    parameter int DEF_MST = 0,
    localparam int IDX_W  = idx_width(NUM_MST)
) (
    input  arb_mode_e          mode,
    input  logic [NUM_MST-1:0] eligible,
    input  logic [IDX_W-1:0]   last_idx,
    output logic [IDX_W-1:0]   win_idx
);

    logic [IDX_W-1:0] fix_idx;
    logic [IDX_W-1:0] rr_idx;

    // Fixed priority: the highest set index overwrites the lower ones.
    always_comb begin
        fix_idx = IDX_W'(DEF_MST);
        for (int i = 0; i < NUM_MST; i++) begin
            if (eligible[i]) fix_idx = IDX_W'(i);
        end
    end

    // Round robin: walk the offsets downward so the nearest offset is assigned last.
    always_comb begin
        rr_idx = IDX_W'(DEF_MST);
        for (int k = NUM_MST; k >= 1; k--) begin
            int j;
            j = (int'(last_idx) + k) % NUM_MST;
            if (eligible[j]) rr_idx = IDX_W'(j);
        end
    end

    always_comb begin
        if (eligible == '0)            win_idx = IDX_W'(DEF_MST);
        else if (mode == MODE_ROUND)   win_idx = rr_idx;
        else                           win_idx = fix_idx;
    end

endmodule

// File: rtl/busarb_top.sv
module busarb_top
    import busarb_pkg::*;
#(
    parameter int NUM_MST  = 4,
    parameter int DEF_MST  = 0,
    parameter bit SPLIT_EN = 1'b1,
    localparam int IDX_W   = idx_width(NUM_MST)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rr_mode,
    input  logic [NUM_MST-1:0] bus_req,
    input  logic               xfer_ready,
    input  logic               split_resp,
    input  logic [NUM_MST-1:0] split_release,
    output logic [NUM_MST-1:0] bus_grant,
    output logic [IDX_W-1:0]   owner_idx
);

    typedef struct packed {
        logic [NUM_MST-1:0] grant;
        logic [IDX_W-1:0]   gidx;
        logic [IDX_W-1:0]   owner;
    } arb_state_t;

    localparam arb_state_t RESET_ST = '{
        grant: NUM_MST'(1) << DEF_MST,
        gidx:  IDX_W'(DEF_MST),
        owner: IDX_W'(DEF_MST)
    };

    arb_state_t         st_d, st_q;
    logic [NUM_MST-1:0] split_set;
    logic [NUM_MST-1:0] mask_now;
    logic [NUM_MST-1:0] eligible;
    logic [IDX_W-1:0]   win_idx;

    // A split response targets the master currently in the data phase.
    always_comb begin
        split_set = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (split_resp && (st_q.owner == IDX_W'(i))) split_set[i] = 1'b1;
        end
    end

    busarb_mask #(
        .NUM_MST  (NUM_MST),
        .SPLIT_EN (SPLIT_EN)
    ) i_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (split_set),
        .clr_vec  (split_release),
        .mask_now (mask_now)
    );

    assign eligible = bus_req & ~mask_now;

    busarb_pick #(
        .NUM_MST (NUM_MST),
        .DEF_MST (DEF_MST)
    ) i_pick (
        .mode     (arb_mode_e'(rr_mode)),
        .eligible (eligible),
        .last_idx (st_q.gidx),
        .win_idx  (win_idx)
    );

    always_comb begin
        st_d = st_q;
        if (xfer_ready) begin
            st_d.grant = NUM_MST'(1) << win_idx;
            st_d.gidx  = win_idx;
            st_d.owner = st_q.gidx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign bus_grant = st_q.grant;
    assign owner_idx = st_q.owner;

endmodule

// File: rtl/busarb_chk.sv
module busarb_chk
    import busarb_pkg::*;
#(
    parameter int NUM_MST = 4,
    parameter int DEF_MST = 0,
    localparam int IDX_W  = idx_width(NUM_MST)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_MST-1:0] bus_req,
    input logic               xfer_ready,
    input logic [NUM_MST-1:0] bus_grant,
    input logic [IDX_W-1:0]   owner_idx
);

    localparam logic [NUM_MST-1:0] DEF_OH = NUM_MST'(1) << DEF_MST;

    logic [IDX_W-1:0] grant_pos;

    always_comb begin
        grant_pos = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (bus_grant[i]) grant_pos = IDX_W'(i);
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bus_grant) == 1); // R3

    AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_ready |=> $stable(bus_grant) && $stable(owner_idx)); // R2

    AST_OWNER_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ready |=> owner_idx == $past(grant_pos)); // R3

    AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ready && bus_req == '0) |=> bus_grant == DEF_OH); // R6

    AST_GRANT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ready |=> ((bus_grant & $past(bus_req)) != '0) || (bus_grant == DEF_OH)); // R8

endmodule

bind busarb_top busarb_chk #(
    .NUM_MST (NUM_MST),
    .DEF_MST (DEF_MST)
) i_chk (.*);

// File: tb/test_busarb_top.sv
`timescale 1ns/1ps
module test_busarb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rr_mode = 1'b0;
    logic [N-1:0] bus_req = '0;
    logic         xfer_ready = 1'b0;
    logic         split_resp = 1'b0;
    logic [N-1:0] split_release = '0;
    logic [N-1:0] bus_grant, ns_grant;
    logic [1:0]   owner_idx, ns_owner;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    busarb_top #(.NUM_MST(N), .DEF_MST(0), .SPLIT_EN(1'b1)) i_busarb_top (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .bus_req(bus_req),
        .xfer_ready(xfer_ready), .split_resp(split_resp), .split_release(split_release),
        .bus_grant(bus_grant), .owner_idx(owner_idx));

    busarb_top #(.NUM_MST(N), .DEF_MST(0), .SPLIT_EN(1'b0)) i_busarb_top_nosplit (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .bus_req(bus_req),
        .xfer_ready(xfer_ready), .split_resp(split_resp), .split_release(split_release),
        .bus_grant(ns_grant), .owner_idx(ns_owner));

    typedef struct packed {
        logic         rr;
        logic [N-1:0] req;
        logic         rdy;
        logic [N-1:0] g;
        logic [1:0]   o;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'b0000, 1'b1, 4'b0001, 2'd0},
        '{1'b0, 4'b0110, 1'b1, 4'b0100, 2'd0},
        '{1'b0, 4'b1011, 1'b0, 4'b0100, 2'd0},
        '{1'b0, 4'b1011, 1'b1, 4'b1000, 2'd2},
        '{1'b0, 4'b0011, 1'b1, 4'b0010, 2'd3},
        '{1'b1, 4'b1111, 1'b1, 4'b0100, 2'd1},
        '{1'b1, 4'b1111, 1'b1, 4'b1000, 2'd2},
        '{1'b1, 4'b1111, 1'b1, 4'b0001, 2'd3},
        '{1'b1, 4'b1010, 1'b1, 4'b0010, 2'd0},
        '{1'b1, 4'b1010, 1'b1, 4'b1000, 2'd1},
        '{1'b1, 4'b1010, 1'b1, 4'b0010, 2'd3},
        '{1'b1, 4'b0010, 1'b1, 4'b0010, 2'd1},
        '{1'b1, 4'b0000, 1'b1, 4'b0001, 2'd1},
        '{1'b1, 4'b0100, 1'b0, 4'b0001, 2'd1},
        '{1'b1, 4'b0100, 1'b1, 4'b0100, 2'd0}
    };

    task automatic check(input string tag, input logic [N-1:0] g, input logic [1:0] o,
                         input logic [N-1:0] eg, input logic [1:0] eo);
        checks++;
        if (g !== eg || o !== eo) begin
            bad++;
            $display("FAIL %s: grant=%b owner=%0d expected grant=%b owner=%0d", tag, g, o, eg, eo);
        end
    endtask

    task automatic apply(input logic rr, input logic [N-1:0] req, input logic rdy,
                         input logic sr, input logic [N-1:0] rel);
        rr_mode = rr; bus_req = req; xfer_ready = rdy;
        split_resp = sr; split_release = rel;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", bus_grant, owner_idx, 4'b0001, 2'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", bus_grant, owner_idx, 4'b0001, 2'd0);
        check("R1 nosplit", ns_grant, ns_owner, 4'b0001, 2'd0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            apply(VEC[v].rr, VEC[v].req, VEC[v].rdy, 1'b0, '0);
            if (!VEC[v].rdy)          tag = "R2 hold";
            else if (VEC[v].req == 0) tag = "R6 idle";
            else if (VEC[v].rr)       tag = "R5 round robin / R3";
            else                      tag = "R4 fixed / R3";
            check($sformatf("%s vec%0d", tag, v), bus_grant, owner_idx, VEC[v].g, VEC[v].o);
        end

        // Split masking: bring master 3 into the data phase first.
        apply(1'b0, 4'b1000, 1'b1, 1'b0, '0);
        check("R4 setup", bus_grant, owner_idx, 4'b1000, 2'd2);
        apply(1'b0, 4'b1000, 1'b1, 1'b0, '0);
        check("R3 setup", bus_grant, owner_idx, 4'b1000, 2'd3);
        apply(1'b0, 4'b1000, 1'b1, 1'b1, '0);
        check("R8 all masked", bus_grant, owner_idx, 4'b0001, 2'd3);
        check("R9 split ignored", ns_grant, ns_owner, 4'b1000, 2'd3);
        apply(1'b0, 4'b1001, 1'b1, 1'b0, '0);
        check("R7 masked skipped", bus_grant, owner_idx, 4'b0001, 2'd0);
        apply(1'b0, 4'b1001, 1'b0, 1'b0, 4'b1000);
        check("R2 release while not ready", bus_grant, owner_idx, 4'b0001, 2'd0);
        apply(1'b0, 4'b1001, 1'b1, 1'b0, '0);
        check("R7 released", bus_grant, owner_idx, 4'b1000, 2'd0);
        check("R9 nosplit", ns_grant, ns_owner, 4'b1000, 2'd3);

        $display("test done: total=%0d bad=%0d", checks, bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule